// File: doc/BRIEF.md
# All-Digital First-Order Phase-Locked Loop Core

This block is a synchronous phase-locked loop built only from logic. A phase detector compares a reference with the feedback signal. The feedback comes from a divide-by-N counter outside the block. The detector steers an up/down counter whose modulus is set at run time. That counter's overflow and underflow strobes feed an increment/decrement stage. The stage moves the edges of a square-wave output forward or back. The output drives the external divider, and this closes a first-order loop.

There are two detectors. The first is an exclusive-OR comparator. The second is an edge-triggered set/clear comparator. A single select input picks between them at run time. A 4-bit length code sets the loop gain. Small codes give a short counter, which means a wide capture range and fast lock. Large codes give a long counter, which means a narrow range and slow lock. Code zero stops the counter.

The counter runs on `k_clk_i`. The output stage runs on `id_clk_i`, a double-rate clock: one I/D period spans two of its cycles. With no corrections, `id_o` completes one cycle every four `id_clk_i` cycles, which is half the I/D rate. With an external divide-by-N, the loop centre frequency is therefore `id_clk_i`/(4N), which equals the I/D rate divided by 2N.

Top module: `dpll_core`

## Requirements
- R1: With `det_sel_i` = 0 (exclusive-OR detector), the counter counts up in cycles where the synchronised `ref_i` and `fb_i` differ, and counts down in cycles where they match.
- R2: With `det_sel_i` = 1 (edge detector), a rising edge of `ref_i` sets the count direction to up and a rising edge of `fb_i` sets it to down. Falling edges leave the direction unchanged.
- R3: While `len_code_i` is 0, `carry_o` and `borrow_o` stay low.
- R4: For a nonzero code c, the counter has modulus 2^(c+2). When counting steadily up, consecutive `carry_o` pulses are exactly 2^(c+2) `k_clk_i` cycles apart. When counting steadily down, consecutive `borrow_o` pulses are the same distance apart.
- R5: `carry_o` and `borrow_o` are single-cycle pulses and are never high together.
- R6: A change of `len_code_i` resets the count to zero. The next carry therefore comes 2^(c+2)+1 cycles after the change, whatever count was held before, and no strobe is issued in the cycle after the change.
- R7: With no strobes, every half-period of `id_o` lasts exactly two `id_clk_i` cycles.
- R8: A carry shortens one half-period of `id_o` to one cycle, which advances the phase. A borrow stretches one half-period to three cycles, which retards it. At most one correction is applied per half-period.
- R9: In a closed loop with a divide-by-8 feedback, the feedback frequency follows the reference. This holds with the reference at the centre frequency and with the reference offset by about 6 %. The net carry-minus-borrow rate matches the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk_i | input | 1 | Counter and detector clock |
| id_clk_i | input | 1 | Double-rate clock for the output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference signal |
| fb_i | input | 1 | Feedback from the external divide-by-N |
| det_sel_i | input | 1 | Detector select: 0 exclusive-OR, 1 edge |
| len_code_i | input | CODE_W | Counter length code; 0 disables the counter |
| id_o | output | 1 | Phase-corrected output to the divider |
| carry_o | output | 1 | One-cycle overflow strobe (`k_clk_i` domain) |
| borrow_o | output | 1 | One-cycle underflow strobe (`k_clk_i` domain) |

## Verification
The properties assume that `len_code_i` is driven synchronously to `k_clk_i`, so that a code change is seen by the counter on the same edge the checker sees it. They also assume that `ref_i` and `fb_i` change no faster than the synchronisers can follow. The bench drives every input on the falling edge of one shared clock, which feeds both clock ports. This also keeps each strobe several output cycles apart, so the toggle handoff between the clock domains never merges two events. Loop stimulus uses reference periods whose required correction rate stays well under one carry per eight cycles.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic {
    DET_XOR  = 1'b0,
    DET_EDGE = 1'b1
  } det_sel_e;
endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
  import dpll_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ref_i,
  input  logic     fb_i,
  input  det_sel_e sel_i,
  output logic     up_o
);
  logic [SYNC_STAGES-1:0] ref_sync_q, fb_sync_q;
  logic ref_d_q, fb_d_q, edge_q;
  logic ref_s, fb_s, ref_rise, fb_rise;

  assign ref_s    = ref_sync_q[SYNC_STAGES-1];
  assign fb_s     = fb_sync_q[SYNC_STAGES-1];
  assign ref_rise = ref_s & ~ref_d_q;
  assign fb_rise  = fb_s & ~fb_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_sync_q <= '0;
      fb_sync_q  <= '0;
      ref_d_q    <= 1'b0;
      fb_d_q     <= 1'b0;
      edge_q     <= 1'b0;
    end else begin
      ref_sync_q <= {ref_sync_q[SYNC_STAGES-2:0], ref_i};
      fb_sync_q  <= {fb_sync_q[SYNC_STAGES-2:0], fb_i};
      ref_d_q    <= ref_s;
      fb_d_q     <= fb_s;
      // simultaneous rises hold the previous direction
      if (ref_rise && !fb_rise)      edge_q <= 1'b1;
      else if (fb_rise && !ref_rise) edge_q <= 1'b0;
    end
  end

  assign up_o = (sel_i == DET_EDGE) ? edge_q : (ref_s ^ fb_s);
endmodule

// File: rtl/dpll_k_counter.sv
module dpll_k_counter #(
  parameter int CODE_W = 4,
  localparam int CNT_W = (1 << CODE_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              up_i,
  output logic              carry_o,
  output logic              borrow_o
);
  logic [CNT_W-1:0]  cnt_q, mask;
  logic [CODE_W-1:0] code_q;
  logic              carry_q, borrow_q;

  always_comb mask = (CNT_W'(1) << (int'(code_i) + 2)) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      code_q   <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
      if (code_i != code_q) begin
        code_q <= code_i;
        cnt_q  <= '0;
      end else if (code_i == '0) begin
        cnt_q <= '0;
      end else if (up_i) begin
        if ((cnt_q & mask) == mask) begin
          cnt_q   <= '0;
          carry_q <= 1'b1;
        end else begin
          cnt_q <= (cnt_q + CNT_W'(1)) & mask;
        end
      end else begin
        if ((cnt_q & mask) == '0) begin
          cnt_q    <= mask;
          borrow_q <= 1'b1;
        end else begin
          cnt_q <= (cnt_q - CNT_W'(1)) & mask;
        end
      end
    end
  end

  assign carry_o  = carry_q;
  assign borrow_o = borrow_q;
endmodule

// File: rtl/dpll_id_stage.sv
module dpll_id_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic car_tgl_i,
  input  logic bor_tgl_i,
  output logic id_o
);
  logic [1:0] car_s_q, bor_s_q;
  logic car_d_q, bor_d_q, car_ev, bor_ev;
  logic car_pend_q, bor_pend_q, half_q, ext_q, id_q;
  logic half_n, ext_n, flip, car_use, bor_use;

  assign car_ev = car_s_q[1] ^ car_d_q;
  assign bor_ev = bor_s_q[1] ^ bor_d_q;

  // half_q: second cycle of a half-period; ext_q: borrow stretch pending
  always_comb begin
    half_n  = half_q;
    ext_n   = ext_q;
    flip    = 1'b0;
    car_use = 1'b0;
    bor_use = 1'b0;
    if (!half_q) begin
      if (car_pend_q) begin
        flip    = 1'b1;
        car_use = 1'b1;
      end else begin
        half_n = 1'b1;
        if (bor_pend_q) begin
          ext_n   = 1'b1;
          bor_use = 1'b1;
        end
      end
    end else if (ext_q) begin
      ext_n = 1'b0;
    end else begin
      flip   = 1'b1;
      half_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_s_q    <= '0;
      bor_s_q    <= '0;
      car_d_q    <= 1'b0;
      bor_d_q    <= 1'b0;
      car_pend_q <= 1'b0;
      bor_pend_q <= 1'b0;
      half_q     <= 1'b0;
      ext_q      <= 1'b0;
      id_q       <= 1'b0;
    end else begin
      car_s_q    <= {car_s_q[0], car_tgl_i};
      bor_s_q    <= {bor_s_q[0], bor_tgl_i};
      car_d_q    <= car_s_q[1];
      bor_d_q    <= bor_s_q[1];
      car_pend_q <= (car_pend_q & ~car_use) | car_ev;
      bor_pend_q <= (bor_pend_q & ~bor_use) | bor_ev;
      half_q     <= half_n;
      ext_q      <= ext_n;
      if (flip) id_q <= ~id_q;
    end
  end

  assign id_o = id_q;
endmodule

// File: rtl/dpll_core.sv
module dpll_core
  import dpll_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              k_clk_i,
  input  logic              id_clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic              fb_i,
  input  logic              det_sel_i,
  input  logic [CODE_W-1:0] len_code_i,
  output logic              id_o,
  output logic              carry_o,
  output logic              borrow_o
);
  logic up;
  logic car_tgl_q, bor_tgl_q;

  dpll_phase_det #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
    .clk_i  (k_clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_i),
    .fb_i   (fb_i),
    .sel_i  (det_sel_e'(det_sel_i)),
    .up_o   (up)
  );

  dpll_k_counter #(.CODE_W(CODE_W)) u_kc (
    .clk_i    (k_clk_i),
    .rst_ni   (rst_ni),
    .code_i   (len_code_i),
    .up_i     (up),
    .carry_o  (carry_o),
    .borrow_o (borrow_o)
  );

  // strobes cross to the output clock as level toggles
  always_ff @(posedge k_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_tgl_q <= 1'b0;
      bor_tgl_q <= 1'b0;
    end else begin
      car_tgl_q <= car_tgl_q ^ carry_o;
      bor_tgl_q <= bor_tgl_q ^ borrow_o;
    end
  end

  dpll_id_stage u_id (
    .clk_i     (id_clk_i),
    .rst_ni    (rst_ni),
    .car_tgl_i (car_tgl_q),
    .bor_tgl_i (bor_tgl_q),
    .id_o      (id_o)
  );
endmodule

// File: rtl/dpll_core_chk.sv
module dpll_core_chk #(
  parameter int CODE_W = 4
) (
  input logic              k_clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] len_code_i,
  input logic              carry_o,
  input logic              borrow_o
);
  assert_exclusive_R5: assert property (@(posedge k_clk_i) disable iff (!rst_ni)
    !(carry_o && borrow_o));

  assert_carry_single_R5: assert property (@(posedge k_clk_i) disable iff (!rst_ni)
    carry_o |=> !carry_o);

  assert_borrow_single_R5: assert property (@(posedge k_clk_i) disable iff (!rst_ni)
    borrow_o |=> !borrow_o);

  assert_disabled_quiet_R3: assert property (@(posedge k_clk_i) disable iff (!rst_ni)
    (len_code_i == '0) |=> (!carry_o && !borrow_o));

  assert_reload_quiet_R6: assert property (@(posedge k_clk_i) disable iff (!rst_ni)
    (len_code_i != $past(len_code_i)) |=> (!carry_o && !borrow_o));
endmodule

bind dpll_core dpll_core_chk #(.CODE_W(CODE_W)) u_chk (
  .k_clk_i    (k_clk_i),
  .rst_ni     (rst_ni),
  .len_code_i (len_code_i),
  .carry_o    (carry_o),
  .borrow_o   (borrow_o)
);

// File: tb/sim_dpll_core.sv
`timescale 1ns/1ps
module sim_dpll_core;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int DIV_N      = 8;
  localparam int WIN        = 3200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_man = 1'b0, fb_man = 1'b0, det_sel = 1'b0;
  logic [3:0] code = 4'd0;
  logic loop_en = 1'b0;
  logic ref_gen = 1'b0, fb_div = 1'b1;
  logic id_o, carry_o, borrow_o;
  logic ref_w, fb_w;

  int checks = 0, fails = 0;
  int n_car = 0, n_bor = 0, n_both = 0, n_car2 = 0, n_bor2 = 0;
  int h1 = 0, h2 = 0, h3 = 0, hx = 0, run = 2;
  int n_ref_r = 0, n_fb_r = 0, div_cnt = 0, ref_cnt = 0, ref_half = 16;
  logic car_p = 1'b0, bor_p = 1'b0, id_p = 1'b0, fb_p = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ref_w = loop_en ? ref_gen : ref_man;
  assign fb_w  = loop_en ? fb_div  : fb_man;

  dpll_core u0 (
    .k_clk_i    (clk),
    .id_clk_i   (clk),
    .rst_ni     (rst_ni),
    .ref_i      (ref_w),
    .fb_i       (fb_w),
    .det_sel_i  (det_sel),
    .len_code_i (code),
    .id_o       (id_o),
    .carry_o    (carry_o),
    .borrow_o   (borrow_o)
  );

  // monitor, external divider and reference generator
  always @(negedge clk) begin
    if (carry_o) n_car++;
    if (borrow_o) n_bor++;
    if (carry_o && borrow_o) n_both++;
    if (carry_o && car_p) n_car2++;
    if (borrow_o && bor_p) n_bor2++;
    car_p = carry_o;
    bor_p = borrow_o;
    if (id_o != id_p) begin
      if (run == 1) h1++;
      else if (run == 2) h2++;
      else if (run == 3) h3++;
      else hx++;
      run = 1;
      if (id_o) div_cnt = (div_cnt + 1) % DIV_N;
    end else begin
      run++;
    end
    id_p = id_o;
    fb_div = (div_cnt < DIV_N/2);
    if (fb_div && !fb_p) n_fb_r++;
    fb_p = fb_div;
    if (loop_en) begin
      if (ref_cnt >= ref_half - 1) begin
        ref_cnt = 0;
        ref_gen = ~ref_gen;
        if (ref_gen) n_ref_r++;
      end else begin
        ref_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // count strobes over a window, after settling
  task automatic strobe_window(input int settle, input int len, output int c, output int b);
    int c0, b0;
    step(settle);
    c0 = n_car; b0 = n_bor;
    step(len);
    c = n_car - c0;
    b = n_bor - b0;
  endtask

  task automatic test_reset;
    check(id_o == 1'b0, "R7 reset id_o", int'(id_o), 0);
    check(!carry_o && !borrow_o, "R5 reset strobes", int'(carry_o) + int'(borrow_o), 0);
  endtask

  task automatic test_xor_r1;
    int c, b;
    det_sel = 1'b0; code = 4'd1;
    ref_man = 1'b1; fb_man = 1'b0;
    strobe_window(16, 64, c, b);
    check(c >= 7 && c <= 9 && b == 0, "R1 xor differ counts up", c * 100 + b, 800);
    fb_man = 1'b1;
    strobe_window(16, 64, c, b);
    check(b >= 7 && b <= 9 && c == 0, "R1 xor match counts down", b * 100 + c, 800);
    ref_man = 1'b0;
    strobe_window(16, 64, c, b);
    check(c >= 7 && c <= 9 && b == 0, "R1 xor fb-only counts up", c * 100 + b, 800);
  endtask

  task automatic test_edge_r2;
    int c, b;
    det_sel = 1'b1; code = 4'd1;
    ref_man = 1'b0; fb_man = 1'b0;
    step(8);
    ref_man = 1'b1;
    strobe_window(16, 64, c, b);
    check(c >= 7 && c <= 9 && b == 0, "R2 ref rise sets up", c * 100 + b, 800);
    fb_man = 1'b1;
    strobe_window(16, 64, c, b);
    check(b >= 7 && b <= 9 && c == 0, "R2 fb rise sets down", b * 100 + c, 800);
    ref_man = 1'b0;
    strobe_window(16, 64, c, b);
    check(b >= 7 && b <= 9 && c == 0, "R2 ref fall keeps down", b * 100 + c, 800);
    fb_man = 1'b0;
    step(8);
    ref_man = 1'b1;
    strobe_window(16, 64, c, b);
    check(c >= 7 && c <= 9 && b == 0, "R2 second ref rise sets up", c * 100 + b, 800);
  endtask

  task automatic test_disabled_r3_r7;
    int c, b, s1, s2, s3, sx;
    det_sel = 1'b0; ref_man = 1'b1; fb_man = 1'b0;
    code = 4'd0;
    step(16);
    s1 = h1; s2 = h2; s3 = h3; sx = hx;
    strobe_window(0, 128, c, b);
    check(c == 0 && b == 0, "R3 code 0 no strobes", c + b, 0);
    check(h1 == s1 && h3 == s3 && hx == sx, "R7 only 2-cycle halves",
          (h1 - s1) + (h3 - s3) + (hx - sx), 0);
    check((h2 - s2) >= 62 && (h2 - s2) <= 64, "R7 half count in 128 cycles", h2 - s2, 64);
  endtask

  task automatic gap_r4(input logic [3:0] cd, input bit up);
    int n, exp;
    exp = 1 << (int'(cd) + 2);
    det_sel = 1'b0; fb_man = 1'b0; ref_man = up;
    code = cd;
    step(8);
    n = 0;
    while (!(up ? carry_o : borrow_o) && n < 2000) begin step(1); n++; end
    n = 0;
    step(1); n++;
    while (!(up ? carry_o : borrow_o) && n < 2000) begin step(1); n++; end
    check(n == exp, up ? "R4 carry spacing" : "R4 borrow spacing", n, exp);
  endtask

  task automatic test_reload_r6;
    int n;
    det_sel = 1'b0; ref_man = 1'b1; fb_man = 1'b0;
    code = 4'd3;
    step(8);
    n = 0;
    while (!carry_o && n < 2000) begin step(1); n++; end
    step(3);
    code = 4'd1;
    n = 0;
    step(1); n++;
    check(!carry_o && !borrow_o, "R6 quiet after change", int'(carry_o) + int'(borrow_o), 0);
    while (!carry_o && n < 2000) begin step(1); n++; end
    check(n == 9, "R6 carry after code change", n, 9);
  endtask

  task automatic test_pulse_shape_r5;
    check(n_both == 0, "R5 carry and borrow together", n_both, 0);
    check(n_car2 == 0 && n_bor2 == 0, "R5 strobe wider than one cycle", n_car2 + n_bor2, 0);
  endtask

  task automatic test_correct_r8;
    int c, b, s1, s3, sx;
    det_sel = 1'b0; code = 4'd1;
    ref_man = 1'b1; fb_man = 1'b0;
    step(24);
    s1 = h1; s3 = h3; sx = hx;
    strobe_window(0, 128, c, b);
    check((h1 - s1) >= c - 1 && (h1 - s1) <= c + 1, "R8 carry shortens half", h1 - s1, c);
    check(h3 == s3 && hx == sx, "R8 no stretch under carries", (h3 - s3) + (hx - sx), 0);
    fb_man = 1'b1;
    step(24);
    s1 = h1; s3 = h3; sx = hx;
    strobe_window(0, 128, c, b);
    check((h3 - s3) >= b - 1 && (h3 - s3) <= b + 1, "R8 borrow stretches half", h3 - s3, b);
    check(h1 == s1 && hx == sx, "R8 no shortening under borrows", (h1 - s1) + (hx - sx), 0);
  endtask

  task automatic test_loop_r9(input int half);
    int r0, f0, c0, b0, dr, df, net, exp_net, period;
    period = 2 * half;
    det_sel = 1'b0; code = 4'd1;
    ref_half = half; ref_cnt = 0;
    loop_en = 1'b1;
    step(WIN);
    r0 = n_ref_r; f0 = n_fb_r; c0 = n_car; b0 = n_bor;
    step(WIN);
    dr = n_ref_r - r0; df = n_fb_r - f0;
    net = (n_car - c0) - (n_bor - b0);
    exp_net = WIN * (4 * DIV_N - period) / period;
    check(df >= dr - 1 && df <= dr + 1, "R9 feedback tracks reference", df, dr);
    check(net >= exp_net - 48 && net <= exp_net + 48, "R9 net correction rate", net, exp_net);
    loop_en = 1'b0;
    step(8);
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(4);
    test_reset();
    rst_ni = 1'b1;
    step(2);
    test_disabled_r3_r7();
    test_xor_r1();
    test_edge_r2();
    gap_r4(4'd1, 1'b1);
    gap_r4(4'd2, 1'b1);
    gap_r4(4'd4, 1'b1);
    gap_r4(4'd2, 1'b0);
    test_reload_r6();
    test_correct_r8();
    test_loop_r9(16);
    test_loop_r9(15);
    test_loop_r9(17);
    test_pulse_shape_r5();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule